// File: doc/BRIEF.md
# Word FIFO pair with flush and trigger levels

This block holds the data path between a processor and a serial bus engine. It has two first-in first-out queues of 32-bit words. The transmit queue is loaded by register writes and drained by the engine. The receive queue is loaded by the engine and drained by register reads. A control register selects a trigger level for each queue and holds one flush request per queue. A status register reports the free space in the transmit queue and the fill level of the receive queue. Two level-sensitive request outputs tell software when a queue needs service.

A word pushed by the engine may be the last word of a message and hold fewer than four bytes. The engine gives the number of valid bytes with each push. The block clears the byte lanes that are not valid, so software always reads zeros above the last valid byte. Software misuse is recorded in two sticky flags: a write into a full transmit queue, and a read from an empty receive queue. Each flag is cleared by flushing its own queue.

Top module: `wfifo_pair`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0x80, `tx_req` is 1, `rx_req` is 0, `eng_tx_valid`, `tx_ovf` and `rx_unf` are 0, and `eng_rx_ready` is 1.
- R2: Words written to register address 2 appear on `eng_tx_data` in write order. `eng_tx_valid` is high while the transmit queue is non-empty. A cycle with `eng_tx_pop` high removes the head word.
- R3: `eng_rx_bytes` gives the number of valid bytes in a pushed word: code 0 means all four bytes, and codes 1 to 3 mean that many low bytes. Invalid upper bytes are stored as zero. Reads of address 3 return the received words in order and remove each word read.
- R4: Address 1 reads transmit free slots in bits 7:4 and receive fill count in bits 3:0. The value reflects a push or pop from the cycle after that push or pop.
- R5: At address 0, bit 1 requests a transmit flush and bit 0 requests a receive flush. Bits 7:5 hold the transmit trigger and bits 4:2 hold the receive trigger. The trigger fields read back as written.
- R6: A flush bit reads 1 in the cycle after the write that set it, then clears by itself. At that clock edge the selected queue becomes empty and the other queue is left unchanged.
- R7: `tx_req` is 1 exactly when the transmit free count is at least the transmit trigger plus one.
- R8: `rx_req` is 1 exactly when the receive fill count is at least the receive trigger plus one.
- R9: A write to address 2 while the transmit queue holds 8 words is dropped and sets `tx_ovf`. `tx_ovf` stays set until a transmit flush.
- R10: A read of address 3 while the receive queue is empty returns 0 and sets `rx_unf`. `rx_unf` stays set until a receive flush.
- R11: An engine push into a full receive queue is ignored: the fill count stays 8, the stored words are unchanged, and `eng_rx_ready` is 0 while the queue is full.
- R12: A push and a pop on the same cycle leave the fill count unchanged and keep word order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for the receive-data pop) |
| reg_addr | input | 3 | Register address: 0 control, 1 status, 2 transmit data, 3 receive data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from the address |
| eng_tx_valid | output | 1 | Transmit queue holds a word |
| eng_tx_data | output | 32 | Head word of the transmit queue |
| eng_tx_pop | input | 1 | Engine takes the head transmit word |
| eng_rx_ready | output | 1 | Receive queue has space |
| eng_rx_push | input | 1 | Engine stores a received word |
| eng_rx_data | input | 32 | Received word, low bytes first |
| eng_rx_bytes | input | 2 | Valid bytes in the pushed word, 0 meaning four |
| tx_req | output | 1 | Transmit data request |
| rx_req | output | 1 | Receive data request |
| tx_ovf | output | 1 | Sticky transmit overflow |
| rx_unf | output | 1 | Sticky receive underflow |

## Verification
The hardest cases to reach are the one-cycle window in which a flush bit is still set and the conditions at the full and empty boundaries. The bench reads the control register in the cycle right after the flush write, so it sees the bit as 1. It then reads the register again and sees the bit cleared. To reach the boundaries, the bench fills a queue to eight words and then issues one more push or write. It then checks that the extra word was discarded and that the sticky flag survives later traffic and is cleared only by the flush of its own queue.

// File: rtl/wfq_pkg.sv
`timescale 1ns/1ps
package wfq_pkg;
   localparam int REG_AW = 3;
   typedef enum logic [REG_AW-1:0] {
      RA_CTRL = 3'd0,
      RA_STAT = 3'd1,
      RA_TXD  = 3'd2,
      RA_RXD  = 3'd3
   } reg_addr_e;
   localparam int CTL_RXF_BIT = 0;
   localparam int CTL_TXF_BIT = 1;
   localparam int CTL_RXT_LSB = 2;
   localparam int CTL_TXT_LSB = 5;
endpackage

// File: rtl/word_fifo.sv
`timescale 1ns/1ps
module word_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 8,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [W-1:0]  push_data,
   input  logic          pop,
   output logic [W-1:0]  head,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);
   localparam bit POW2 = (DEPTH & (DEPTH - 1)) == 0;

   if (DEPTH < 2) begin : bad_depth
      $error("word_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp, wp_nx, rp_nx;
   logic          do_push, do_pop;

   if (POW2) begin : g_wrap_free
      assign wp_nx = wp + 1'b1;
      assign rp_nx = rp + 1'b1;
   end else begin : g_wrap_cmp
      assign wp_nx = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      assign rp_nx = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
   end

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;
   assign head    = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= wp_nx;
         if (do_pop)  rp <= rp_nx;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R4
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   // R6
   flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty);
   // R12
   same_cycle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop && !empty && !full && !flush) |=> count == $past(count));
   // R11
   full_push_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !flush) |=> full);
endmodule

// File: rtl/lane_mask.sv
`timescale 1ns/1ps
module lane_mask #(
   parameter int W   = 32,
   localparam int NB = W / 8,
   localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
   input  logic [W-1:0]  word_in,
   input  logic [BW-1:0] nbytes,
   output logic [W-1:0]  word_out
);
   if (W % 8 != 0) begin : bad_width
      $error("lane_mask: W must be a whole number of bytes");
   end

   for (genvar i = 0; i < NB; i++) begin : g_lane
      logic keep;
      assign keep = (nbytes == '0) || (BW'(i) < nbytes);
      assign word_out[i*8 +: 8] = keep ? word_in[i*8 +: 8] : 8'h00;
   end
endmodule

// File: rtl/level_cmp.sv
`timescale 1ns/1ps
module level_cmp #(
   parameter int LW = 4,
   parameter int TW = 3,
   localparam int MW = ((LW > TW) ? LW : TW) + 1
) (
   input  logic [LW-1:0] level,
   input  logic [TW-1:0] trig,
   output logic          req
);
   // level >= trig + 1 is the same as level > trig
   assign req = MW'(level) > MW'(trig);
endmodule

// File: rtl/wfifo_pair.sv
`timescale 1ns/1ps
module wfifo_pair #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 8,
   parameter int TRIG_W = 3,
   parameter int FILL_W = 4,
   localparam int CW    = $clog2(DEPTH + 1),
   localparam int BW    = $clog2(DATA_W / 8)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              eng_tx_valid,
   output logic [DATA_W-1:0] eng_tx_data,
   input  logic              eng_tx_pop,
   output logic              eng_rx_ready,
   input  logic              eng_rx_push,
   input  logic [DATA_W-1:0] eng_rx_data,
   input  logic [BW-1:0]     eng_rx_bytes,
   output logic              tx_req,
   output logic              rx_req,
   output logic              tx_ovf,
   output logic              rx_unf
);
   import wfq_pkg::*;

   if (DATA_W != 32) begin : bad_data_w
      $error("wfifo_pair: register port carries 32-bit words");
   end
   if (CTL_RXT_LSB + TRIG_W > CTL_TXT_LSB || CTL_TXT_LSB + TRIG_W > 32) begin : bad_trig
      $error("wfifo_pair: trigger fields overlap");
   end
   if (CW > FILL_W || 2 * FILL_W > 32) begin : bad_fill
      $error("wfifo_pair: status nibble too narrow for DEPTH");
   end
   if ((1 << TRIG_W) < DEPTH) begin : bad_range
      $error("wfifo_pair: trigger cannot span DEPTH");
   end

   logic [TRIG_W-1:0] tx_trig, rx_trig;
   logic              tx_pend, rx_pend;
   logic [CW-1:0]     tx_cnt, rx_cnt, tx_free;
   logic              tx_full, tx_empty, rx_full, rx_empty;
   logic [DATA_W-1:0] rx_head, rx_masked;
   logic              wr_ctrl, wr_txd, rd_rxd;

   assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
   assign wr_txd  = reg_wr && (reg_addr == RA_TXD);
   assign rd_rxd  = reg_rd && (reg_addr == RA_RXD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_trig <= '0;
         rx_trig <= '0;
         tx_pend <= 1'b0;
         rx_pend <= 1'b0;
         tx_ovf  <= 1'b0;
         rx_unf  <= 1'b0;
      end else begin
         tx_pend <= wr_ctrl && reg_wdata[CTL_TXF_BIT];
         rx_pend <= wr_ctrl && reg_wdata[CTL_RXF_BIT];
         if (wr_ctrl) begin
            tx_trig <= reg_wdata[CTL_TXT_LSB +: TRIG_W];
            rx_trig <= reg_wdata[CTL_RXT_LSB +: TRIG_W];
         end
         if (tx_pend)                 tx_ovf <= 1'b0;
         else if (wr_txd && tx_full)  tx_ovf <= 1'b1;
         if (rx_pend)                 rx_unf <= 1'b0;
         else if (rd_rxd && rx_empty) rx_unf <= 1'b1;
      end
   end

   word_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(tx_pend),
      .push(wr_txd), .push_data(reg_wdata),
      .pop(eng_tx_pop), .head(eng_tx_data),
      .count(tx_cnt), .full(tx_full), .empty(tx_empty)
   );

   lane_mask #(.W(DATA_W)) u_mask (
      .word_in(eng_rx_data), .nbytes(eng_rx_bytes), .word_out(rx_masked)
   );

   word_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(rx_pend),
      .push(eng_rx_push), .push_data(rx_masked),
      .pop(rd_rxd), .head(rx_head),
      .count(rx_cnt), .full(rx_full), .empty(rx_empty)
   );

   assign tx_free      = CW'(DEPTH) - tx_cnt;
   assign eng_tx_valid = !tx_empty;
   assign eng_rx_ready = !rx_full;

   level_cmp #(.LW(CW), .TW(TRIG_W)) u_txlvl (.level(tx_free), .trig(tx_trig), .req(tx_req));
   level_cmp #(.LW(CW), .TW(TRIG_W)) u_rxlvl (.level(rx_cnt),  .trig(rx_trig), .req(rx_req));

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         RA_CTRL: begin
            reg_rdata[CTL_TXF_BIT] = tx_pend;
            reg_rdata[CTL_RXF_BIT] = rx_pend;
            reg_rdata[CTL_TXT_LSB +: TRIG_W] = tx_trig;
            reg_rdata[CTL_RXT_LSB +: TRIG_W] = rx_trig;
         end
         RA_STAT: begin
            reg_rdata[FILL_W +: FILL_W] = FILL_W'(tx_free);
            reg_rdata[0 +: FILL_W]      = FILL_W'(rx_cnt);
         end
         RA_RXD:  reg_rdata = rx_empty ? '0 : rx_head;
         default: reg_rdata = '0;
      endcase
   end

   // R9
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ovf && !tx_pend) |=> tx_ovf);
   // R10
   unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_unf && !rx_pend) |=> rx_unf);
   // R10
   unf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rxd && !eng_rx_ready && 1'b0) || !(reg_addr == RA_RXD && rx_cnt == '0) || reg_rdata == '0);
   // R7
   empty_tx_requests_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_tx_valid |-> tx_req);
   // R6
   flush_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_pend && !wr_ctrl) |=> !tx_pend);
   // R2
   tx_becomes_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_txd && !tx_pend) |=> eng_tx_valid);
endmodule

// File: tb/tb_wfifo_pair.sv
`timescale 1ns/1ps
module tb_wfifo_pair;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_wr, reg_rd;
   logic [2:0]  reg_addr;
   logic [31:0] reg_wdata, reg_rdata;
   logic        eng_tx_valid, eng_tx_pop, eng_rx_ready, eng_rx_push;
   logic [31:0] eng_tx_data, eng_rx_data;
   logic [1:0]  eng_rx_bytes;
   logic        tx_req, rx_req, tx_ovf, rx_unf;

   int n_cmp = 0;
   int n_mis = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   wfifo_pair dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data), .eng_tx_pop(eng_tx_pop),
      .eng_rx_ready(eng_rx_ready), .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
      .eng_rx_bytes(eng_rx_bytes), .tx_req(tx_req), .rx_req(rx_req),
      .tx_ovf(tx_ovf), .rx_unf(rx_unf)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_mis++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // all driver tasks start just after a falling edge and end just after one
   task automatic reg_write(logic [2:0] a, logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(logic [2:0] a, output logic [31:0] v);
      reg_rd = 1'b1; reg_addr = a;
      #1 v = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic tx_pop();
      eng_tx_pop = 1'b1;
      @(negedge clk);
      eng_tx_pop = 1'b0;
   endtask

   task automatic rx_push(logic [31:0] d, logic [1:0] b);
      eng_rx_push = 1'b1; eng_rx_data = d; eng_rx_bytes = b;
      @(negedge clk);
      eng_rx_push = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      reg_read(3'd0, v); chk("R1 ctrl", v, 32'h0);
      reg_read(3'd1, v); chk("R1 status", v, 32'h80);
      chk("R1 flags", {tx_req, rx_req, eng_tx_valid, tx_ovf, rx_unf, eng_rx_ready},
          {26'd0, 6'b100001});
   endtask

   task automatic t_tx_order();
      logic [31:0] v;
      reg_write(3'd2, 32'h1111_0001);
      reg_write(3'd2, 32'h2222_0002);
      reg_write(3'd2, 32'h3333_0003);
      reg_read(3'd1, v); chk("R4 tx free 5", v, 32'h50);
      chk("R2 valid", {31'd0, eng_tx_valid}, 32'd1);
      chk("R2 head0", eng_tx_data, 32'h1111_0001); tx_pop();
      chk("R2 head1", eng_tx_data, 32'h2222_0002); tx_pop();
      chk("R2 head2", eng_tx_data, 32'h3333_0003); tx_pop();
      chk("R2 drained", {31'd0, eng_tx_valid}, 32'd0);
      // R12 same-cycle write and pop
      reg_write(3'd2, 32'hA0A0_0004);
      reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 32'hB0B0_0005; eng_tx_pop = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; eng_tx_pop = 1'b0;
      reg_read(3'd1, v); chk("R12 level kept", v, 32'h70);
      chk("R12 order", eng_tx_data, 32'hB0B0_0005);
      tx_pop();
   endtask

   task automatic t_rx_partial();
      logic [31:0] v;
      rx_push(32'hAABB_CCDD, 2'd0);
      rx_push(32'h1122_3344, 2'd1);
      rx_push(32'h9988_7766, 2'd2);
      rx_push(32'hDEAD_BEEF, 2'd3);
      reg_read(3'd1, v); chk("R4 rx fill 4", v, 32'h84);
      reg_read(3'd3, v); chk("R3 four bytes", v, 32'hAABB_CCDD);
      reg_read(3'd3, v); chk("R3 one byte", v, 32'h0000_0044);
      reg_read(3'd3, v); chk("R3 two bytes", v, 32'h0000_7766);
      reg_read(3'd3, v); chk("R3 three bytes", v, 32'h00AD_BEEF);
      reg_read(3'd1, v); chk("R4 rx drained", v, 32'h80);
   endtask

   task automatic t_triggers();
      logic [31:0] v;
      reg_write(3'd0, 32'h44);   // tx trig 2 (bits 7:5), rx trig 1 (bits 4:2)
      reg_read(3'd0, v); chk("R5 readback", v, 32'h44);
      for (int i = 0; i < 5; i++) reg_write(3'd2, 32'h500 + i);
      chk("R7 free 3 trig 2", {31'd0, tx_req}, 32'd1);
      reg_write(3'd2, 32'h505);
      chk("R7 free 2 trig 2", {31'd0, tx_req}, 32'd0);
      rx_push(32'h1, 2'd0);
      chk("R8 fill 1 trig 1", {31'd0, rx_req}, 32'd0);
      rx_push(32'h2, 2'd0);
      chk("R8 fill 2 trig 1", {31'd0, rx_req}, 32'd1);
      reg_write(3'd0, 32'h47);
      reg_read(3'd0, v); chk("R6 bits still set", v, 32'h47);
      reg_read(3'd0, v); chk("R6 bits cleared", v, 32'h44);
      reg_read(3'd1, v); chk("R6 both empty", v, 32'h80);
      chk("R7 R8 after flush", {30'd0, tx_req, rx_req}, 32'b10);
      reg_write(3'd0, 32'h0);
   endtask

   task automatic t_flush_selective();
      logic [31:0] v;
      reg_write(3'd2, 32'hC0DE_0001);
      reg_write(3'd2, 32'hC0DE_0002);
      rx_push(32'h7777_7777, 2'd0);
      reg_write(3'd0, 32'h01);
      @(negedge clk);
      reg_read(3'd1, v); chk("R6 rx only", v, 32'h60);
      chk("R6 tx untouched", eng_tx_data, 32'hC0DE_0001);
      reg_write(3'd0, 32'h02);
      @(negedge clk);
      reg_read(3'd1, v); chk("R6 tx flushed", v, 32'h80);
   endtask

   task automatic t_overflow();
      logic [31:0] v;
      for (int i = 0; i < 8; i++) reg_write(3'd2, 32'h100 + i);
      reg_read(3'd1, v); chk("R4 tx full", v, 32'h00);
      chk("R9 no flag yet", {31'd0, tx_ovf}, 32'd0);
      reg_write(3'd2, 32'hBAD);
      chk("R9 flag set", {31'd0, tx_ovf}, 32'd1);
      reg_read(3'd1, v); chk("R9 level kept", v, 32'h00);
      for (int i = 0; i < 8; i++) begin
         chk("R9 word kept", eng_tx_data, 32'h100 + i);
         tx_pop();
      end
      chk("R9 extra dropped", {31'd0, eng_tx_valid}, 32'd0);
      chk("R9 still sticky", {31'd0, tx_ovf}, 32'd1);
      reg_write(3'd0, 32'h02);
      @(negedge clk);
      chk("R9 cleared by flush", {31'd0, tx_ovf}, 32'd0);
   endtask

   task automatic t_underflow();
      logic [31:0] v;
      reg_read(3'd3, v); chk("R10 empty read zero", v, 32'h0);
      chk("R10 flag set", {31'd0, rx_unf}, 32'd1);
      rx_push(32'h5A5A_A5A5, 2'd0);
      reg_read(3'd3, v); chk("R10 data after", v, 32'h5A5A_A5A5);
      chk("R10 still sticky", {31'd0, rx_unf}, 32'd1);
      reg_write(3'd0, 32'h02);
      @(negedge clk);
      chk("R10 other flush keeps", {31'd0, rx_unf}, 32'd1);
      reg_write(3'd0, 32'h01);
      @(negedge clk);
      chk("R10 cleared by flush", {31'd0, rx_unf}, 32'd0);
   endtask

   task automatic t_rx_full();
      logic [31:0] v;
      for (int i = 0; i < 9; i++) rx_push(32'h200 + i, 2'd0);
      reg_read(3'd1, v); chk("R11 fill 8", v, 32'h88);
      chk("R11 not ready", {31'd0, eng_rx_ready}, 32'd0);
      for (int i = 0; i < 8; i++) begin
         reg_read(3'd3, v); chk("R11 word order", v, 32'h200 + i);
      end
      reg_read(3'd1, v); chk("R11 drained", v, 32'h80);
      chk("R11 no underflow", {31'd0, rx_unf}, 32'd0);
   endtask

   initial begin
      rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
      eng_tx_pop = 0; eng_rx_push = 0; eng_rx_data = 0; eng_rx_bytes = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_tx_order();
      t_rx_partial();
      t_triggers();
      t_flush_selective();
      t_overflow();
      t_underflow();
      t_rx_full();
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
         $finish;
      end
   end

   initial begin
      #(100_000);
      if (!finished) begin
         finished = 1'b1;
         n_cmp++; n_mis++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
         $finish;
      end
   end
endmodule